// File: doc/BRIEF.md
# Phase-Split Video/CPU Memory Multiplexer

This block lets a video fetch unit and a CPU share a single RAM by splitting every CPU clock cycle into two equal halves. The RAM side runs on a clock at twice the CPU rate. A one-bit phase toggles on every RAM clock edge. In the first half the video address drives the RAM, and any returned word is captured for the display side with a one-cycle valid pulse. In the second half the CPU address, write data and write strobe drive the RAM, and CPU read data is captured when that half ends.

Sometimes one slot per cycle is not enough for the display side. It then raises a burst request, which is sampled at the end of a second half. During the CPU cycle that follows, video also owns the second-half slot, CPU ready is held low and CPU writes cannot reach the RAM. A counter limits how many stalled CPU cycles can run back to back. Once the limit is reached, the CPU gets at least one full cycle before video can claim its slot again.

Top module: `vid_cpu_mux`

## Requirements
- R1: After reset `phase_o` is 0 (first half). It inverts on every `clk` edge, so each CPU cycle is one clock with `phase_o`=0 followed by one clock with `phase_o`=1.
- R2: While `phase_o` is 0, `ram_addr` equals `vid_addr` and `ram_we` is 0.
- R3: At the clock edge that ends a slot owned by video, if `vid_req` is 1 the word on `ram_rdata` is stored into `vid_data` and `vid_valid` is 1 for the next clock only. With `vid_req` at 0 no pulse appears. Every such request produces exactly one pulse.
- R4: While `phase_o` is 1 and `cpu_ready` is 1, `ram_addr`, `ram_wdata` and `ram_we` follow `cpu_addr`, `cpu_wdata` and `cpu_we`.
- R5: `cpu_rdata` is loaded from `ram_rdata` only at the edge that ends a second half with `cpu_ready` 1 and `cpu_we` 0. In all other cycles it holds its value, and that includes writes and stalled cycles.
- R6: `vid_burst` is sampled at the edge that ends a second half. When the request is accepted, `cpu_ready` is 0 for both halves of the next CPU cycle and video owns that cycle's second-half slot (`ram_addr` equals `vid_addr`).
- R7: `ram_we` is never 1 while `cpu_ready` is 0, so a CPU write issued during a stalled cycle leaves RAM unchanged.
- R8: No more than MAX_STALL CPU cycles in a row have `cpu_ready` 0. If `vid_burst` stays high, the cycle after the limit is a ready cycle.
- R9: During and directly after reset, `cpu_ready` is 1, `vid_valid` is 0 and `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM clock, twice the CPU rate |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_o | output | 1 | 0 = first half, 1 = second half of the CPU cycle |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rdata | output | DW | CPU read data captured at end of second half |
| cpu_ready | output | 1 | Low during a stalled CPU cycle |
| vid_req | input | 1 | Video wants a fetch in the current slot |
| vid_burst | input | 1 | Video claims the second-half slot of the next CPU cycle |
| vid_addr | input | AW | Video fetch address |
| vid_data | output | DW | Fetched video word |
| vid_valid | output | 1 | One-clock pulse marking a new `vid_data` |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | DW | RAM read data, valid in the same clock |

## Verification
The bench builds the block with AW=6, DW=8 and MAX_STALL=2. With these values the RAM model is small enough to compare word by word at the end of the run. A burst request held for eight cycles reaches the stall limit several times, showing the stalled, stalled, granted pattern. The same run shows whether CPU writes issued in stalled cycles leak into RAM, and whether any second-half video fetch is lost or doubled.

// File: rtl/vid_cpu_mux.sv
module vid_cpu_mux #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int MAX_STALL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          phase_o,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_we,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  input  logic          vid_req,
  input  logic          vid_burst,
  input  logic [AW-1:0] vid_addr,
  output logic [DW-1:0] vid_data,
  output logic          vid_valid,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  input  logic [DW-1:0] ram_rdata
);
  localparam int CW = $clog2(MAX_STALL + 1);

  logic          phase;
  logic          stall;
  logic [CW-1:0] run;

  wire vid_slot = !phase || stall;
  wire fetch    = vid_slot && vid_req;
  wire grant    = vid_burst && (32'(run) < 32'(MAX_STALL));

  assign phase_o   = phase;
  assign cpu_ready = !stall;
  assign ram_addr  = vid_slot ? vid_addr : cpu_addr;
  assign ram_wdata = cpu_wdata;
  assign ram_we    = phase && !stall && cpu_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      stall     <= 1'b0;
      run       <= '0;
      vid_valid <= 1'b0;
      vid_data  <= '0;
      cpu_rdata <= '0;
    end else begin
      phase     <= !phase;
      vid_valid <= fetch;
      if (fetch) vid_data <= ram_rdata;
      if (phase) begin
        if (!stall && !cpu_we) cpu_rdata <= ram_rdata;
        stall <= grant;
        run   <= grant ? run + 1'b1 : '0;
      end
    end
  end
endmodule

module vid_cpu_mux_chk #(
  parameter int DW        = 8,
  parameter int MAX_STALL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phase_o,
  input logic          cpu_ready,
  input logic          ram_we,
  input logic          vid_valid,
  input logic          vid_req,
  input logic [DW-1:0] cpu_rdata
);
  int stalled_run;

  always_ff @(posedge clk) begin
    if (!rst_n) stalled_run <= 0;
    else if (!phase_o) stalled_run <= cpu_ready ? 0 : stalled_run + 1;
  end

  a_r1_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_o != $past(phase_o));
  a_r2_first_half_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o |-> !ram_we);
  a_r3_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> $past(vid_req));
  a_r5_rdata_changes_after_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_rdata) |-> (!phase_o && $past(cpu_ready)));
  a_r6_ready_steady_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o |-> $stable(cpu_ready));
  a_r7_no_write_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> !ram_we);
  a_r8_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stalled_run <= MAX_STALL);
endmodule

bind vid_cpu_mux vid_cpu_mux_chk #(.DW(DW), .MAX_STALL(MAX_STALL)) chk (
  .clk(clk), .rst_n(rst_n), .phase_o(phase_o), .cpu_ready(cpu_ready),
  .ram_we(ram_we), .vid_valid(vid_valid), .vid_req(vid_req), .cpu_rdata(cpu_rdata)
);

// File: tb/vid_cpu_mux_test.sv
module vid_cpu_mux_test;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int MS = 2;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_o, cpu_we = 1'b0, cpu_ready, vid_req = 1'b0, vid_burst = 1'b0, vid_valid, ram_we;
  logic [AW-1:0] cpu_addr = '0, vid_addr = '0, ram_addr;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, vid_data, ram_wdata, ram_rdata;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] ref_mem [N];
  logic [DW-1:0] vq [$];
  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_stall = 0;
  int exp_run = 0;
  logic [DW-1:0] exp_rdata = '0;

  always #2 clk = !clk;

  vid_cpu_mux #(.AW(AW), .DW(DW), .MAX_STALL(MS)) uut (
    .clk(clk), .rst_n(rst_n), .phase_o(phase_o),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .vid_req(vid_req), .vid_burst(vid_burst), .vid_addr(vid_addr),
    .vid_data(vid_data), .vid_valid(vid_valid),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && vid_valid) begin
      if (vq.size() == 0) chk("R3 unexpected vid_valid", 1, 0);
      else chk("R3 vid_data", vid_data, vq.pop_front());
    end
  end

  task automatic cycle(input logic [AW-1:0] ca, input logic [DW-1:0] cd, input logic we,
                       input logic vr1, input logic [AW-1:0] va1,
                       input logic vr2, input logic [AW-1:0] va2, input logic vb);
    bit nxt;
    chk("R1 phase first half", phase_o, 0);
    chk("R6 ready at cycle start", cpu_ready, !exp_stall);
    cpu_addr = ca; cpu_wdata = cd; cpu_we = we;
    vid_req = vr1; vid_addr = va1; vid_burst = 1'b0;
    if (vr1) vq.push_back(ref_mem[va1]);
    #1;
    chk("R2 first half addr", ram_addr, va1);
    chk("R2 first half we", ram_we, 0);
    @(negedge clk);
    chk("R1 phase second half", phase_o, 1);
    vid_req = exp_stall ? vr2 : 1'b0;
    vid_addr = va2; vid_burst = vb;
    if (exp_stall && vr2) vq.push_back(ref_mem[va2]);
    #1;
    if (exp_stall) begin
      chk("R6 video owns second half", ram_addr, va2);
      chk("R7 no write while stalled", ram_we, 0);
      chk("R6 ready low", cpu_ready, 0);
    end else begin
      chk("R4 cpu addr", ram_addr, ca);
      chk("R4 cpu we", ram_we, we);
      if (we) chk("R4 cpu wdata", ram_wdata, cd);
      if (we) ref_mem[ca] = cd;
      else exp_rdata = ref_mem[ca];
    end
    @(negedge clk);
    chk("R5 cpu_rdata", cpu_rdata, exp_rdata);
    nxt = vb && (exp_run < MS);
    exp_run = nxt ? exp_run + 1 : 0;
    exp_stall = nxt;
    vid_req = 1'b0; vid_burst = 1'b0; cpu_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mem[i] = DW'(i * 7 + 3);
      ref_mem[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk("R9 ready in reset", cpu_ready, 1);
    chk("R9 valid in reset", vid_valid, 0);
    chk("R9 rdata in reset", cpu_rdata, 0);
    chk("R1 phase in reset", phase_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++)
      cycle(AW'(i), DW'(i) ^ 8'hA5, 1'b1, 1'b1, AW'(i + 32), 1'b0, '0, 1'b0);
    for (int i = 0; i < 16; i++)
      cycle(AW'(i), '0, 1'b0, i[0], AW'(i), 1'b0, '0, 1'b0);
    for (int k = 0; k < 8; k++)
      cycle(AW'(40 + k), DW'(k + 8'h50), 1'b1, 1'b1, AW'(k), 1'b1, AW'(k + 16), 1'b1);
    chk("R8 ready after held burst", cpu_ready, !exp_stall);
    for (int k = 0; k < 8; k++)
      cycle(AW'(40 + k), '0, 1'b0, 1'b1, AW'(40 + k), 1'b1, '0, 1'b0);
    cycle(AW'(3), '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1);
    cycle(AW'(5), 8'hEE, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
    cycle(AW'(5), '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R3 no lost video fetch", vq.size(), 0);
    begin
      int bad = 0;
      for (int i = 0; i < N; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk("R7 ram contents", bad, 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule